// File: doc/BRIEF.md
# Software-Loaded Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses using two small, fully associative entry sets. One set serves instruction fetches and the other serves data reads and writes. Hardware never fills the sets on its own. Software stages an entry in a tag register and a data register. It then writes an operation register, which commits the staged pair into one of the two sets or clears both sets. Every entry covers a 1 MB page. An entry carries an 8-bit address-space ID, a shared flag that makes the ID irrelevant, a lock flag that protects the entry from replacement, a cache-mode field and read, write, execute and supervisor-only permissions.

A lookup request carries an address, an access type, a privilege flag and the current address-space ID. The result appears one cycle later. It is one of three outcomes: a hit with the translated address and attributes, a miss that records the faulting address, or a permission fault. A status register reports the outcome. After a miss, software can commit an identity mapping for the page and retry the access.

Top module: `soft_tlb`

## Requirements
- R1: After reset, no result is flagged, translation is off, and the control, status and fault-address registers read as zero.
- R2: The registers sit at these byte offsets: control 0x00 (bit 0 enables translation), operation 0x04 (reads as zero), status 0x08, fault address 0x10, tag 0x14 and data 0x18. The tag and data registers read back exactly the value written to them.
- R3: Tag fields are: bit 0 valid, bit 1 shared, bits [9:2] address-space ID, bits [31:20] page. Data fields are: bit 1 lock, bit 2 execute, bit 3 write, bit 4 read, bit 5 supervisor-only, bits [7:6] cache mode, bits [31:20] physical page. Writing the operation register with bit 0 set commits the staged pair. Bit 4 clear selects the data set and bit 4 set selects the instruction set. Access type 00 is read and 01 is write; both look up the data set. Type 1x is execute and looks up the instruction set.
- R4: With translation on, a matching lookup returns a hit one cycle after the request. The physical address is {physical page, virtual address [19:0]}. The result also carries the entry's cache mode (00 write-through, 01 copy-back, 10 non-cacheable precise) and its permissions as {supervisor-only, read, write, execute}. Status bit 1 is set on a hit.
- R5: An entry with the shared bit set matches any address-space ID. An entry without it matches only when its ID equals the request's ID.
- R6: A lookup that matches nothing flags a miss and clears status bits 1 to 6. The full 32-bit request address is stored in the fault-address register.
- R7: A matching entry reports a fault instead of a hit in these cases. A user access to a supervisor-only entry sets status bit 5; this check has first priority. Otherwise, a missing execute permission sets bit 6, a missing write permission sets bit 3, and a missing read permission sets bit 4, each for the access type that needs that permission.
- R8: A commit whose page and ID equal those of a valid entry in the chosen set overwrites that entry, even when the entry is locked.
- R9: Any other commit goes to the first entry that is not locked, searching from a round-robin pointer. The pointer then moves past that entry. If every entry is locked, the commit is dropped and status bit 8 is set. Status bit 8 is cleared by the next commit that is not dropped.
- R10: Writing the operation register with bit 7 set invalidates every entry in both sets, locked entries included, and returns the replacement pointers to entry 0. If bit 0 is also set in that write, the commit does not happen.
- R11: With translation off, every lookup is a hit with physical address equal to the virtual address, cache mode 00 and permissions 0111.
- R12: A lookup requested in the same cycle as a commit or a clear sees the entry contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 32 | Lookup virtual address |
| lkType | input | 2 | Access type: 00 read, 01 write, 1x execute |
| lkSuper | input | 1 | Request is made in supervisor mode |
| lkAsid | input | 8 | Current address-space ID |
| rsValid | output | 1 | Lookup result present |
| rsHit | output | 1 | Translation succeeded |
| rsMiss | output | 1 | No entry matched |
| rsFault | output | 1 | Entry matched but access not permitted |
| rsPaddr | output | 32 | Translated address (meaningful on hit) |
| rsCacheMode | output | 2 | Cache mode of the hit |
| rsPerm | output | 4 | {supervisor-only, read, write, execute} |

## Verification
A lookup and a table write can land on the same clock edge. The table write is either a commit of a staged entry or a clear of all entries. The bench provokes this by asserting a lookup in the same cycle as the operation-register write. A lookup that falls in the same cycle as a commit must still miss, and a lookup that falls in the same cycle as a clear must still hit. A second lookup issued right after that edge must show the new contents. The bench also fills the table so that the round-robin pointer wraps onto a locked entry, and it fills a set with locked entries only, which forces a commit to be dropped.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 20;
  localparam int VPN_W      = ADDR_W - PAGE_SHIFT;
  localparam int ASID_W     = 8;
  localparam int REG_AW     = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_OP    = 8'h04;
  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_FAULT = 8'h10;
  localparam logic [REG_AW-1:0] OFS_TAG   = 8'h14;
  localparam logic [REG_AW-1:0] OFS_DATA  = 8'h18;

  // strobes from register control to the datapath
  typedef struct packed {
    logic commit;
    logic toInstr;
    logic flushAll;
  } tlbCmd_t;

  // attributes returned by a matching entry
  typedef struct packed {
    logic             supv;
    logic             rd;
    logic             wr;
    logic             ex;
    logic [1:0]       cacheMode;
    logic [VPN_W-1:0] ppn;
  } tlbAttr_t;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic              lock;
    tlbAttr_t          attr;
  } tlbEntry_t;
endpackage

// File: rtl/soft_tlb_ctrl.sv
module soft_tlb_ctrl
  import soft_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic [ADDR_W-1:0] statusWord,
  input  logic [ADDR_W-1:0] faultAddr,
  output logic [ADDR_W-1:0] regRdata,
  output tlbCmd_t           cmd,
  output tlbEntry_t         stagedEnt,
  output logic              transEn
);
  logic [ADDR_W-1:0] tagReg;
  logic [ADDR_W-1:0] dataReg;
  logic              opWr;

  assign opWr = regWr && (regAddr == OFS_OP);

  // clear wins over commit in the same write
  always_comb begin
    cmd.flushAll = opWr && regWdata[7];
    cmd.commit   = opWr && regWdata[0] && !regWdata[7];
    cmd.toInstr  = regWdata[4];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagReg  <= '0;
      dataReg <= '0;
      transEn <= 1'b0;
    end else if (regWr) begin
      case (regAddr)
        OFS_CTRL: transEn <= regWdata[0];
        OFS_TAG:  tagReg  <= regWdata;
        OFS_DATA: dataReg <= regWdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    stagedEnt.valid          = tagReg[0];
    stagedEnt.shared         = tagReg[1];
    stagedEnt.asid           = tagReg[9:2];
    stagedEnt.vpn            = tagReg[ADDR_W-1:PAGE_SHIFT];
    stagedEnt.lock           = dataReg[1];
    stagedEnt.attr.ex        = dataReg[2];
    stagedEnt.attr.wr        = dataReg[3];
    stagedEnt.attr.rd        = dataReg[4];
    stagedEnt.attr.supv      = dataReg[5];
    stagedEnt.attr.cacheMode = dataReg[7:6];
    stagedEnt.attr.ppn       = dataReg[ADDR_W-1:PAGE_SHIFT];
  end

  always_comb begin
    case (regAddr)
      OFS_CTRL:  regRdata = {{(ADDR_W-1){1'b0}}, transEn};
      OFS_STAT:  regRdata = statusWord;
      OFS_FAULT: regRdata = faultAddr;
      OFS_TAG:   regRdata = tagReg;
      OFS_DATA:  regRdata = dataReg;
      default:   regRdata = '0;
    endcase
  end

  AST_ENABLE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFS_CTRL) |=> (transEn == $past(regWdata[0]))); // R2
endmodule

// File: rtl/soft_tlb_set.sv
module soft_tlb_set
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              commitEn,
  input  logic              flushAll,
  input  tlbEntry_t         newEnt,
  input  logic [VPN_W-1:0]  qVpn,
  input  logic [ASID_W-1:0] qAsid,
  output logic              qHit,
  output tlbAttr_t          qAttr,
  output logic              commitDrop
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlbEntry_t          ent [ENTRIES];
  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   nextPtr;
  logic [IDX_W-1:0]   owIdx;
  logic               freeFound;
  logic               owHit;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] lockedVec;
  logic [ENTRIES-1:0] qMatch;
  logic [ENTRIES-1:0] owMatch;

  for (genvar i = 0; i < ENTRIES; i++) begin : gCmp
    assign validVec[i]  = ent[i].valid;
    assign lockedVec[i] = ent[i].valid && ent[i].lock;
    assign qMatch[i]    = ent[i].valid && (ent[i].vpn == qVpn) &&
                          (ent[i].shared || (ent[i].asid == qAsid));
    assign owMatch[i]   = ent[i].valid && (ent[i].vpn == newEnt.vpn) &&
                          (ent[i].asid == newEnt.asid);
  end

  // lowest matching index wins
  always_comb begin
    qHit  = 1'b0;
    qAttr = '0;
    owHit = 1'b0;
    owIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (qMatch[i]) begin
        qHit  = 1'b1;
        qAttr = ent[i].attr;
      end
      if (owMatch[i]) begin
        owHit = 1'b1;
        owIdx = IDX_W'(i);
      end
    end
  end

  // first unlocked slot at or after the pointer
  always_comb begin : repSel
    int idx;
    freeFound = 1'b0;
    victim    = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      idx = (int'(rrPtr) + k) % ENTRIES;
      if (!lockedVec[idx]) begin
        freeFound = 1'b1;
        victim    = IDX_W'(idx);
      end
    end
    nextPtr = (int'(victim) == ENTRIES - 1) ? '0 : victim + IDX_W'(1);
  end

  assign commitDrop = commitEn && !flushAll && !owHit && !freeFound;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
      rrPtr <= '0;
    end else if (flushAll) begin
      for (int i = 0; i < ENTRIES; i++) ent[i].valid <= 1'b0;
      rrPtr <= '0;
    end else if (commitEn) begin
      if (owHit) begin
        ent[owIdx] <= newEnt;
      end else if (freeFound) begin
        ent[victim] <= newEnt;
        rrPtr       <= nextPtr;
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (validVec == '0)); // R10
  AST_DROP_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rstN)
    commitDrop |=> $stable(validVec)); // R9
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    commitDrop |-> ($countones(lockedVec) == ENTRIES)); // R9
endmodule

// File: rtl/soft_tlb_dp.sv
module soft_tlb_dp
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbCmd_t           cmd,
  input  tlbEntry_t         stagedEnt,
  input  logic              transEn,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkVaddr,
  input  logic [1:0]        lkType,
  input  logic              lkSuper,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              rsValid,
  output logic              rsHit,
  output logic              rsMiss,
  output logic              rsFault,
  output logic [ADDR_W-1:0] rsPaddr,
  output logic [1:0]        rsCacheMode,
  output logic [3:0]        rsPerm,
  output logic [ADDR_W-1:0] statusWord,
  output logic [ADDR_W-1:0] faultAddr
);
  localparam int NSETS = 2;

  logic [NSETS-1:0] setHit;
  logic [NSETS-1:0] setDrop;
  tlbAttr_t         setAttr [NSETS];

  for (genvar s = 0; s < NSETS; s++) begin : gSet
    soft_tlb_set #(.ENTRIES(ENTRIES)) set_i (
      .clk       (clk),
      .rstN      (rstN),
      .commitEn  (cmd.commit && (cmd.toInstr == 1'(s))),
      .flushAll  (cmd.flushAll),
      .newEnt    (stagedEnt),
      .qVpn      (lkVaddr[ADDR_W-1:PAGE_SHIFT]),
      .qAsid     (lkAsid),
      .qHit      (setHit[s]),
      .qAttr     (setAttr[s]),
      .commitDrop(setDrop[s])
    );
  end

  logic              selI;
  tlbAttr_t          hitAttr;
  logic              nHit, nMiss, nFault, nRf, nWf, nXf, nSpf;
  logic [ADDR_W-1:0] nPa;
  logic [1:0]        nCm;
  logic [3:0]        nPerm;
  logic              stHit, stWf, stRf, stSpf, stXf, stOvf;

  always_comb begin
    selI    = lkType[1];
    hitAttr = setAttr[selI];
    nHit = 1'b0; nMiss = 1'b0; nFault = 1'b0;
    nRf  = 1'b0; nWf   = 1'b0; nXf    = 1'b0; nSpf = 1'b0;
    nPa  = '0;   nCm   = 2'b00; nPerm = 4'b0000;
    if (!transEn) begin
      nHit  = 1'b1;
      nPa   = lkVaddr;
      nPerm = 4'b0111;
    end else if (!setHit[selI]) begin
      nMiss = 1'b1;
    end else begin
      nPerm = {hitAttr.supv, hitAttr.rd, hitAttr.wr, hitAttr.ex};
      nCm   = hitAttr.cacheMode;
      if (hitAttr.supv && !lkSuper)              nSpf = 1'b1;
      else if (lkType[1] && !hitAttr.ex)          nXf  = 1'b1;
      else if (lkType == 2'b01 && !hitAttr.wr)    nWf  = 1'b1;
      else if (lkType == 2'b00 && !hitAttr.rd)    nRf  = 1'b1;
      nFault = nSpf | nXf | nWf | nRf;
      nHit   = !nFault;
      if (nHit) nPa = {hitAttr.ppn, lkVaddr[PAGE_SHIFT-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsValid <= 1'b0; rsHit <= 1'b0; rsMiss <= 1'b0; rsFault <= 1'b0;
      rsPaddr <= '0;   rsCacheMode <= 2'b00; rsPerm <= 4'b0000;
      stHit <= 1'b0; stWf <= 1'b0; stRf <= 1'b0; stSpf <= 1'b0; stXf <= 1'b0;
      stOvf <= 1'b0;
      faultAddr <= '0;
    end else begin
      rsValid <= lkValid;
      rsHit   <= lkValid && nHit;
      rsMiss  <= lkValid && nMiss;
      rsFault <= lkValid && nFault;
      if (lkValid) begin
        rsPaddr     <= nPa;
        rsCacheMode <= nCm;
        rsPerm      <= nPerm;
        stHit <= nHit; stWf <= nWf; stRf <= nRf; stSpf <= nSpf; stXf <= nXf;
        if (nMiss) faultAddr <= lkVaddr;
      end
      if (cmd.commit) stOvf <= |setDrop;
    end
  end

  assign statusWord = {{(ADDR_W-9){1'b0}}, stOvf, 1'b0, stXf, stSpf, stRf, stWf,
                       1'b0, stHit, 1'b0};

  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rsValid); // R4
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rsValid); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    rsValid |-> $onehot({rsHit, rsMiss, rsFault})); // R7
  AST_MISS_CAPTURES_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && transEn && !setHit[lkType[1]]) |=> (faultAddr == $past(lkVaddr))); // R6
  AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !transEn) |=> (rsHit && rsPaddr == $past(lkVaddr))); // R11
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        lkValid,
  input  logic [31:0] lkVaddr,
  input  logic [1:0]  lkType,
  input  logic        lkSuper,
  input  logic [7:0]  lkAsid,
  output logic        rsValid,
  output logic        rsHit,
  output logic        rsMiss,
  output logic        rsFault,
  output logic [31:0] rsPaddr,
  output logic [1:0]  rsCacheMode,
  output logic [3:0]  rsPerm
);
  tlbCmd_t           cmd;
  tlbEntry_t         stagedEnt;
  logic              transEn;
  logic [ADDR_W-1:0] statusWord;
  logic [ADDR_W-1:0] faultAddr;

  soft_tlb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .statusWord(statusWord), .faultAddr(faultAddr),
    .regRdata(regRdata), .cmd(cmd), .stagedEnt(stagedEnt), .transEn(transEn)
  );

  soft_tlb_dp #(.ENTRIES(ENTRIES)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stagedEnt(stagedEnt), .transEn(transEn),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkType(lkType), .lkSuper(lkSuper),
    .lkAsid(lkAsid), .rsValid(rsValid), .rsHit(rsHit), .rsMiss(rsMiss),
    .rsFault(rsFault), .rsPaddr(rsPaddr), .rsCacheMode(rsCacheMode),
    .rsPerm(rsPerm), .statusWord(statusWord), .faultAddr(faultAddr)
  );
endmodule

// File: tb/soft_tlb_tb_top.sv
module soft_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_OP = 8'h04, A_STAT = 8'h08,
                         A_FLT = 8'h10, A_TAG = 8'h14, A_DATA = 8'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        lkValid = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic [1:0]  lkType = 2'b00;
  logic        lkSuper = 1'b0;
  logic [7:0]  lkAsid = '0;
  logic        rsValid, rsHit, rsMiss, rsFault;
  logic [31:0] rsPaddr;
  logic [1:0]  rsCacheMode;
  logic [3:0]  rsPerm;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_tlb dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .lkValid(lkValid), .lkVaddr(lkVaddr), .lkType(lkType),
    .lkSuper(lkSuper), .lkAsid(lkAsid), .rsValid(rsValid), .rsHit(rsHit),
    .rsMiss(rsMiss), .rsFault(rsFault), .rsPaddr(rsPaddr),
    .rsCacheMode(rsCacheMode), .rsPerm(rsPerm)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  typ;
    logic        sup;
    logic [7:0]  asid;
    logic        expHit;
    logic        expMiss;
    logic [31:0] expPa;
    logic [1:0]  expCm;
    logic [7:0]  expStat;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h00D12345, 2'd0, 1'b0, 8'd6, 1'b1, 1'b0, 32'h60D12345, 2'd0, 8'h02}, // R4 R5
    '{32'h00D12345, 2'd0, 1'b0, 8'd5, 1'b0, 1'b1, 32'h0,        2'd0, 8'h00}, // R5 R6
    '{32'h00F00010, 2'd1, 1'b1, 8'd9, 1'b0, 1'b0, 32'h0,        2'd0, 8'h08}, // R7 write
    '{32'h00F00010, 2'd0, 1'b0, 8'd9, 1'b0, 1'b0, 32'h0,        2'd0, 8'h20}, // R7 supv
    '{32'h00F00010, 2'd0, 1'b1, 8'd1, 1'b1, 1'b0, 32'hFFF00010, 2'd2, 8'h02}, // R5 shared
    '{32'h00E00100, 2'd2, 1'b0, 8'd3, 1'b1, 1'b0, 32'h00E00100, 2'd1, 8'h02}, // R3 instr
    '{32'h00E00100, 2'd0, 1'b0, 8'd3, 1'b0, 1'b1, 32'h0,        2'd0, 8'h00}, // R3 data
    '{32'h00D00000, 2'd2, 1'b0, 8'd6, 1'b0, 1'b1, 32'h0,        2'd0, 8'h00}, // R3 exec
    '{32'h00D00004, 2'd1, 1'b0, 8'd6, 1'b1, 1'b0, 32'h60D00004, 2'd0, 8'h02}, // R4 write
    '{32'h01000008, 2'd3, 1'b0, 8'd0, 1'b0, 1'b0, 32'h0,        2'd0, 8'h40}  // R7 exec
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] t, input logic s,
                        input logic [7:0] id);
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = va; lkType = t; lkSuper = s; lkAsid = id;
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  // lookup in the same cycle as an operation-register write
  task automatic lookupWithOp(input logic [31:0] op, input logic [31:0] va,
                              input logic [1:0] t, input logic [7:0] id);
    @(negedge clk);
    regWr = 1'b1; regAddr = A_OP; regWdata = op;
    lkValid = 1'b1; lkVaddr = va; lkType = t; lkSuper = 1'b1; lkAsid = id;
    @(negedge clk);
    regWr = 1'b0; lkValid = 1'b0;
  endtask

  task automatic commit(input logic [31:0] tag, input logic [31:0] dat,
                        input logic [31:0] op);
    regWrite(A_TAG, tag);
    regWrite(A_DATA, dat);
    regWrite(A_OP, op);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rsValid", {31'b0, rsValid}, 32'h0);
    regRead(A_CTRL, rd);  chk("R1 control", rd, 32'h0);
    regRead(A_STAT, rd);  chk("R1 status", rd, 32'h0);
    regRead(A_FLT, rd);   chk("R1 fault addr", rd, 32'h0);

    // R11 translation off
    lookup(32'h12345678, 2'd1, 1'b0, 8'd0);
    chk("R11 hit", {31'b0, rsHit}, 32'h1);
    chk("R11 paddr", rsPaddr, 32'h12345678);
    chk("R11 cm/perm", {26'b0, rsCacheMode, rsPerm}, {26'b0, 2'b00, 4'b0111});
    regRead(A_STAT, rd);  chk("R11 status", rd, 32'h02);

    // R2 register readback
    regWrite(A_TAG, 32'h00D00019);
    regWrite(A_DATA, 32'h60D0001E);
    regRead(A_TAG, rd);   chk("R2 tag", rd, 32'h00D00019);
    regRead(A_DATA, rd);  chk("R2 data", rd, 32'h60D0001E);
    regRead(A_OP, rd);    chk("R2 op reads zero", rd, 32'h0);
    regWrite(A_CTRL, 32'h1);
    regRead(A_CTRL, rd);  chk("R2 control", rd, 32'h1);

    // R3 load both sets
    regWrite(A_OP, 32'h03);                                 // data set, ID 6 locked
    commit(32'h00F00003, 32'hFFF000B0, 32'h03);             // data, shared, R+supv
    commit(32'h00E00003, 32'h00E00054, 32'h13);             // instr, R+X copy-back
    commit(32'h01000003, 32'h01000010, 32'h13);             // instr, read only

    for (int v = 0; v < NVEC; v++) begin
      lookup(VECS[v].va, VECS[v].typ, VECS[v].sup, VECS[v].asid);
      chk("R4/R5/R6/R7 table hit", {31'b0, rsHit}, {31'b0, VECS[v].expHit});
      chk("R6 table miss", {31'b0, rsMiss}, {31'b0, VECS[v].expMiss});
      regRead(A_STAT, rd);
      chk("R7 table status", rd, {24'b0, VECS[v].expStat});
      if (VECS[v].expHit) begin
        chk("R4 table paddr", rsPaddr, VECS[v].expPa);
        chk("R4 table cache mode", {30'b0, rsCacheMode}, {30'b0, VECS[v].expCm});
      end
      if (VECS[v].expMiss) begin
        regRead(A_FLT, rd);
        chk("R6 fault addr", rd, VECS[v].va);
      end
    end

    // R4 permission bits
    lookup(32'h00F00010, 2'd0, 1'b1, 8'd2);
    chk("R4 perm", {28'b0, rsPerm}, {28'b0, 4'b1100});

    // R8 overwrite a locked matching entry
    commit(32'h00D00019, 32'h70D0001E, 32'h03);
    lookup(32'h00D00020, 2'd0, 1'b0, 8'd6);
    chk("R8 overwrite paddr", rsPaddr, 32'h70D00020);

    // R12 + R10 clear in the same cycle as a lookup
    lookupWithOp(32'h80, 32'h00D00020, 2'd0, 8'd6);
    chk("R12 flush sees old", {31'b0, rsHit}, 32'h1);
    lookup(32'h00D00020, 2'd0, 1'b0, 8'd6);
    chk("R10 data cleared", {31'b0, rsMiss}, 32'h1);
    lookup(32'h00E00100, 2'd2, 1'b0, 8'd3);
    chk("R10 instr cleared", {31'b0, rsMiss}, 32'h1);
    commit(32'h00D00019, 32'h60D0001E, 32'h81);
    lookup(32'h00D00000, 2'd0, 1'b0, 8'd6);
    chk("R10 clear beats commit", {31'b0, rsMiss}, 32'h1);

    // R12 commit in the same cycle as a lookup
    lookupWithOp(32'h03, 32'h00D00000, 2'd0, 8'd6);
    chk("R12 commit sees old", {31'b0, rsMiss}, 32'h1);
    lookup(32'h00D00000, 2'd0, 1'b0, 8'd6);
    chk("R12 commit visible next", {31'b0, rsHit}, 32'h1);

    // R9 round robin skipping locked slots
    regWrite(A_OP, 32'h80);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] base;
      base = (32'h100 + k) << 20;
      commit(base | 32'h3, base | 32'h1C | ((k % 2 == 0) ? 32'h2 : 32'h0), 32'h03);
    end
    commit(32'h20000003, 32'h2000001C, 32'h03);
    lookup(32'h10100000, 2'd0, 1'b1, 8'd0);
    chk("R9 unlocked slot evicted", {31'b0, rsMiss}, 32'h1);
    lookup(32'h10000000, 2'd0, 1'b1, 8'd0);
    chk("R9 locked slot kept", {31'b0, rsHit}, 32'h1);
    lookup(32'h20000000, 2'd0, 1'b1, 8'd0);
    chk("R9 new entry present", {31'b0, rsHit}, 32'h1);
    regRead(A_STAT, rd);  chk("R9 no overflow", rd & 32'h100, 32'h0);

    // R9 all locked: commit dropped
    regWrite(A_OP, 32'h80);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] base;
      base = (32'h100 + k) << 20;
      commit(base | 32'h3, base | 32'h1E, 32'h03);
    end
    commit(32'h20000003, 32'h2000001C, 32'h03);
    lookup(32'h20000000, 2'd0, 1'b1, 8'd0);
    chk("R9 dropped commit", {31'b0, rsMiss}, 32'h1);
    regRead(A_STAT, rd);  chk("R9 overflow status", rd, 32'h100);

    // R8 overwrite still allowed when full; clears overflow
    commit(32'h10000003, 32'h3000001E, 32'h03);
    regRead(A_STAT, rd);  chk("R9 overflow cleared", rd & 32'h100, 32'h0);
    lookup(32'h10000010, 2'd0, 1'b1, 8'd0);
    chk("R8 overwrite when full", rsPaddr, 32'h30000010);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule